// File: doc/BRIEF.md
# Reset Pin Deglitcher with Mode-Dependent Filtering

This block sits between an active-low external reset pin and the chip's reset controller. It raises a reset request only when the pin has been low long enough to count as a genuine reset, so that short glitches on the pin are rejected. The amount of filtering is configurable. It can be turned off entirely, so that the pin passes straight through. It can be a counting filter clocked by the bus clock, with a programmable width. It can also be a counting filter clocked by a slow low-power clock, with a fixed width that keeps working while the bus clock is stopped.

Two configuration bytes sit on a simple byte-wide register port. One byte chooses the filter used in run/wait mode and the filter used in stop mode. The other byte sets the bus-clock filter width. Both bytes are cleared only by power-on reset. Any other system reset leaves them as they were, but it clears the state of both filters.

Each filter path has its own clear condition, and the bus-clock path is also cleared on entry to any stop mode. The low-power path is cleared on entry to a low-leakage stop mode. The register port is plain control with no data flow, so it has no valid/ready handshake: a write takes effect on the clock edge at which `cfg_wr` is high, and reads are combinational.

Top module: `rstpin_deglitch`

## Requirements
- R1: After power-on reset, both configuration bytes read 0 and the block is in pass-through mode, so `rst_req` equals the inverse of `pin_n`.
- R2: The control byte is at offset 4, bits 2:0. The width byte is at offset 5, bits 4:0. The remaining bits of both bytes read 0 and ignore writes. Every other offset reads 0.
- R3: In run mode (`in_stop` low), run code 00 (control bits 1:0) and reserved code 11 both select pass-through: `rst_req` is the combinational inverse of `pin_n`.
- R4: Run code 01 selects the bus-clock filter with N = width field + 1 (1 to 32). After two synchronizer flops, a low pulse of N bus cycles asserts `rst_req`, while a pulse of N-1 cycles never does.
- R5: A filter that has asserted deasserts only after N consecutive high samples. Any opposite sample restarts its count.
- R6: Run code 10 selects the low-power-clock filter with a fixed count of 3 `lp_clk` cycles: a 3-cycle low pulse asserts `rst_req`, while a 2-cycle pulse does not.
- R7: While `in_stop` is high, the run code is ignored. Control bit 2 = 0 gives pass-through, and bit 2 = 1 selects the low-power-clock filter.
- R8: The bus-clock filter count and output are cleared whenever that filter is not selected or `in_stop` is high.
- R9: The low-power-clock filter count and output are cleared whenever that filter is not selected or `in_lowleak` is high.
- R10: `sys_rst_n` low clears both filters but leaves both configuration bytes unchanged. Only `por_n` clears the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for registers and the bus-clock filter |
| lp_clk | input | 1 | Low-power clock for the slow filter |
| por_n | input | 1 | Power-on reset, active low, async; clears configuration and filters |
| sys_rst_n | input | 1 | Any other system reset, active low, async; clears filters only |
| pin_n | input | 1 | Raw external reset pin, active low |
| in_stop | input | 1 | Chip is in a stop mode |
| in_lowleak | input | 1 | Chip is in a low-leakage stop mode |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
The hardest situations to reach are the filter clears that happen in the middle of a count. In these cases a partly counted low pulse must be forgotten when the chip briefly enters stop or low-leakage stop. The bench holds the pin low for a counted number of edges, pulses the mode input for a single edge, and keeps the pin low. It then samples `rst_req` at the exact edge where a filter without the clear would already have fired, and samples again later to see that the filter recovers. Each width boundary is reached by sweeping all 32 widths, with pulses of exactly N-1 and N cycles.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;
  // register offsets: software decodes these
  localparam int CTRL_OFS  = 4;
  localparam int WIDTH_OFS = 5;

  // run/wait filter codes (control bits 1:0)
  localparam logic [1:0] RUN_PASS = 2'b00;
  localparam logic [1:0] RUN_BUS  = 2'b01;
  localparam logic [1:0] RUN_SLOW = 2'b10;

  typedef enum logic [1:0] {
    PATH_PASS = 2'd0,
    PATH_BUS  = 2'd1,
    PATH_SLOW = 2'd2
  } path_e;
endpackage

// File: rtl/rstpin_cfg.sv
module rstpin_cfg #(
  parameter int ADDR_W = 3,
  parameter int WID_W  = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [2:0]        ctrl,
  output logic [WID_W-1:0]  width
);
  import rstpin_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(WIDTH_OFS);

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // configuration survives everything but power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl  <= '0;
      width <= '0;
    end else if (wr) begin
      if (addr == A_CTRL)  ctrl  <= wdata[2:0];
      if (addr == A_WIDTH) width <= wdata[WID_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)  rdata[2:0]       = ctrl;
    if (addr == A_WIDTH) rdata[WID_W-1:0] = width;
  end
endmodule

// File: rtl/rstpin_cnt_filter.sv
// Two-flop synchronizer plus a symmetric run-length filter: the output
// flips after tgt+1 consecutive samples that disagree with it.
module rstpin_cnt_filter #(
  parameter int TGT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pin_n,
  input  logic [TGT_W-1:0] tgt,
  output logic             smp_low,
  output logic             fired
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sync_q;
  logic [TGT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], pin_n};
  end

  assign smp_low = ~sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fired <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      fired <= 1'b0;
    end else if (smp_low != fired) begin
      if (cnt_q == tgt) begin
        cnt_q <= '0;
        fired <= ~fired;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rstpin_deglitch.sv
module rstpin_deglitch #(
  parameter int ADDR_W   = 3,
  parameter int WID_W    = 5,
  parameter int LP_COUNT = 3
) (
  input  logic              bus_clk,
  input  logic              lp_clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              pin_n,
  input  logic              in_stop,
  input  logic              in_lowleak,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              rst_req
);
  import rstpin_pkg::*;

  localparam int LP_TGT_W = (LP_COUNT > 1) ? $clog2(LP_COUNT) : 1;
  localparam logic [LP_TGT_W-1:0] LP_TGT = LP_TGT_W'(LP_COUNT - 1);

  logic [2:0]       ctrl;
  logic [WID_W-1:0] width;
  path_e            path;
  logic             any_rst_n;
  logic             bus_clr, lp_clr;
  logic             bus_smp_low, lp_smp_low;
  logic             bus_fired, lp_fired;

  assign any_rst_n = por_n & sys_rst_n;

  rstpin_cfg #(.ADDR_W(ADDR_W), .WID_W(WID_W)) cfg_i (
    .clk(bus_clk), .por_n(por_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl(ctrl), .width(width)
  );

  // path choice: stop mode has its own one-bit selection
  always_comb begin
    if (in_stop) begin
      path = ctrl[2] ? PATH_SLOW : PATH_PASS;
    end else begin
      case (ctrl[1:0])
        RUN_BUS:  path = PATH_BUS;
        RUN_SLOW: path = PATH_SLOW;
        default:  path = PATH_PASS;
      endcase
    end
  end

  assign bus_clr = (path != PATH_BUS) | in_stop;
  assign lp_clr  = (path != PATH_SLOW) | in_lowleak;

  rstpin_cnt_filter #(.TGT_W(WID_W)) bus_filt_i (
    .clk(bus_clk), .rst_n(any_rst_n), .clr(bus_clr), .pin_n(pin_n),
    .tgt(width), .smp_low(bus_smp_low), .fired(bus_fired)
  );

  rstpin_cnt_filter #(.TGT_W(LP_TGT_W)) lp_filt_i (
    .clk(lp_clk), .rst_n(any_rst_n), .clr(lp_clr), .pin_n(pin_n),
    .tgt(LP_TGT), .smp_low(lp_smp_low), .fired(lp_fired)
  );

  always_comb begin
    case (path)
      PATH_BUS:  rst_req = bus_fired;
      PATH_SLOW: rst_req = lp_fired;
      default:   rst_req = ~pin_n;
    endcase
  end
endmodule

// File: rtl/rstpin_deglitch_chk.sv
module rstpin_deglitch_chk #(
  parameter int ADDR_W = 3,
  parameter int WID_W  = 5
) (
  input logic              bus_clk,
  input logic              lp_clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              pin_n,
  input logic              in_stop,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_rdata,
  input logic              rst_req,
  input logic [2:0]        ctrl,
  input logic [WID_W-1:0]  width,
  input logic              bus_clr,
  input logic              lp_clr,
  input logic              bus_smp_low,
  input logic              lp_smp_low,
  input logic              bus_fired,
  input logic              lp_fired
);
  // R2
  reserved_zero_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
    (cfg_addr == ADDR_W'(4)) |-> (cfg_rdata[7:3] == 5'd0));

  // R3
  pass_through_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
    (!in_stop && (ctrl[1:0] == 2'b00 || ctrl[1:0] == 2'b11)) |-> (rst_req == !pin_n));

  // R5
  bus_flip_cause_chk: assert property (@(posedge bus_clk) disable iff (!(por_n && sys_rst_n))
    (!$stable(bus_fired) && !$past(bus_clr)) |-> ($past(bus_smp_low) != $past(bus_fired)));

  // R5
  lp_flip_cause_chk: assert property (@(posedge lp_clk) disable iff (!(por_n && sys_rst_n))
    (!$stable(lp_fired) && !$past(lp_clr)) |-> ($past(lp_smp_low) != $past(lp_fired)));

  // R8
  bus_clear_chk: assert property (@(posedge bus_clk) disable iff (!(por_n && sys_rst_n))
    bus_clr |=> !bus_fired);

  // R9
  lp_clear_chk: assert property (@(posedge lp_clk) disable iff (!(por_n && sys_rst_n))
    lp_clr |=> !lp_fired);

  // R10
  cfg_hold_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
    !cfg_wr |=> ($stable(ctrl) && $stable(width)));
endmodule

bind rstpin_deglitch rstpin_deglitch_chk #(.ADDR_W(ADDR_W), .WID_W(WID_W)) chk_i (
  .bus_clk(bus_clk), .lp_clk(lp_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .pin_n(pin_n), .in_stop(in_stop), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .rst_req(rst_req), .ctrl(ctrl), .width(width),
  .bus_clr(bus_clr), .lp_clr(lp_clr), .bus_smp_low(bus_smp_low),
  .lp_smp_low(lp_smp_low), .bus_fired(bus_fired), .lp_fired(lp_fired)
);

// File: tb/rstpin_deglitch_tb.sv
`timescale 1ns/1ps
module rstpin_deglitch_tb_top;
  logic       bus_clk = 1'b0;
  logic       lp_clk  = 1'b0;
  logic       por_n, sys_rst_n, pin_n, in_stop, in_lowleak, cfg_wr;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       rst_req;
  int         n_vec  = 0;
  int         n_fail = 0;

  always #10 bus_clk = ~bus_clk;   // 50 MHz
  always #70 lp_clk  = ~lp_clk;

  rstpin_deglitch dut_i (
    .bus_clk(bus_clk), .lp_clk(lp_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .pin_n(pin_n), .in_stop(in_stop), .in_lowleak(in_lowleak), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge bus_clk);
    cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge bus_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge bus_clk);
    cfg_addr = 3'(a);
    #1;
    chk(cfg_rdata == 8'(exp), req, cfg_rdata, exp);
  endtask

  task automatic bus_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge bus_clk);
  endtask

  task automatic lp_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge lp_clk);
  endtask

  // low pulse of 'len' bus cycles, watching the output until it settles
  task automatic bus_pulse(input int len, input int n, input string req);
    logic seen = 1'b0;
    int   win  = len + 2 * n + 10;
    @(negedge bus_clk);
    pin_n = 1'b0;
    for (int i = 0; i < win; i++) begin
      if (i == len) pin_n = 1'b1;
      #1 seen |= rst_req;
      @(negedge bus_clk);
    end
    chk(seen == (len >= n), req, seen, (len >= n));
    chk(rst_req == 1'b0, "R5 release", rst_req, 0);
  endtask

  task automatic lp_pulse(input int len, input string req);
    logic seen = 1'b0;
    @(negedge lp_clk);
    pin_n = 1'b0;
    for (int i = 0; i < len + 12; i++) begin
      if (i == len) pin_n = 1'b1;
      #1 seen |= rst_req;
      @(negedge lp_clk);
    end
    chk(seen == (len >= 3), req, seen, (len >= 3));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b0; pin_n = 1'b1; in_stop = 1'b0;
    in_lowleak = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    bus_edges(4);
    por_n = 1'b1; sys_rst_n = 1'b1;
    bus_edges(2);

    // R1 reset state and pass-through
    rd_chk(4, 0, "R1 ctrl");
    rd_chk(5, 0, "R1 width");
    #1 chk(rst_req == 1'b0, "R1 pin high", rst_req, 0);
    pin_n = 1'b0; #1 chk(rst_req == 1'b1, "R1 pin low", rst_req, 1);
    pin_n = 1'b1; #1;

    // R2 register map, reserved bits, other offsets
    wr(4, 8'hFF); wr(5, 8'hFF);
    rd_chk(4, 8'h07, "R2 ctrl");
    rd_chk(5, 8'h1F, "R2 width");
    for (int a = 0; a < 8; a++)
      if (a != 4 && a != 5) rd_chk(a, 0, "R2 empty offset");

    // R3 reserved code 11 and code 00 pass through
    for (int c = 0; c < 4; c += 3) begin
      wr(4, c);
      #1 chk(rst_req == 1'b0, "R3 high", rst_req, 0);
      pin_n = 1'b0; #1 chk(rst_req == 1'b1, "R3 low", rst_req, 1);
      pin_n = 1'b1; #1;
    end

    // R4 sweep all widths with pulses of N-1 and N cycles
    wr(4, 1);
    for (int w = 0; w < 32; w++) begin
      wr(5, w);
      bus_edges(4);
      bus_pulse(w, w + 1, "R4 short");
      bus_pulse(w + 1, w + 1, "R4 exact");
    end

    // R5 an opposite sample restarts the release count (N = 4)
    wr(5, 3);
    bus_edges(4);
    pin_n = 1'b0; bus_edges(10);
    chk(rst_req == 1'b1, "R5 asserted", rst_req, 1);
    pin_n = 1'b1; bus_edges(3);
    pin_n = 1'b0; bus_edges(1);
    pin_n = 1'b1; bus_edges(4);
    chk(rst_req == 1'b1, "R5 restart held", rst_req, 1);
    bus_edges(8);
    chk(rst_req == 1'b0, "R5 released", rst_req, 0);

    // R8 entering stop clears a partial bus count (N = 8)
    wr(5, 7);
    bus_edges(4);
    pin_n = 1'b0; bus_edges(5);
    in_stop = 1'b1; bus_edges(1);
    in_stop = 1'b0; bus_edges(4);
    chk(rst_req == 1'b0, "R8 count cleared", rst_req, 0);
    bus_edges(10);
    chk(rst_req == 1'b1, "R8 recount", rst_req, 1);
    pin_n = 1'b1; bus_edges(20);

    // R6 slow filter, fixed count 3
    wr(4, 2);
    lp_edges(3);
    for (int l = 1; l < 5; l++) lp_pulse(l, "R6 slow pulse");

    // R7 stop mode: bit 2 selects slow filter, run code ignored
    wr(4, 5);
    lp_edges(1);
    in_stop = 1'b1;
    lp_edges(3);
    lp_pulse(2, "R7 stop short");
    lp_pulse(3, "R7 stop long");
    wr(4, 1);
    #1 chk(rst_req == 1'b0, "R7 stop pass high", rst_req, 0);
    pin_n = 1'b0; #1 chk(rst_req == 1'b1, "R7 stop pass low", rst_req, 1);
    pin_n = 1'b1;
    lp_edges(1);
    in_stop = 1'b0;

    // R9 low-leakage stop clears a partial slow count
    wr(4, 6);
    lp_edges(3);
    pin_n = 1'b0; lp_edges(3);
    in_stop = 1'b1; in_lowleak = 1'b1; lp_edges(1);
    in_stop = 1'b0; in_lowleak = 1'b0; lp_edges(1);
    chk(rst_req == 1'b0, "R9 count cleared", rst_req, 0);
    lp_edges(4);
    chk(rst_req == 1'b1, "R9 recount", rst_req, 1);
    pin_n = 1'b1; lp_edges(8);

    // R10 system reset keeps configuration, clears filter
    wr(4, 5); wr(5, 9);
    bus_edges(4);
    pin_n = 1'b0; bus_edges(20);
    chk(rst_req == 1'b1, "R10 pre", rst_req, 1);
    sys_rst_n = 1'b0; #1;
    chk(rst_req == 1'b0, "R10 filter cleared", rst_req, 0);
    bus_edges(2);
    sys_rst_n = 1'b1; bus_edges(1);
    chk(rst_req == 1'b0, "R10 after release", rst_req, 0);
    rd_chk(4, 5, "R10 ctrl kept");
    rd_chk(5, 9, "R10 width kept");
    pin_n = 1'b1; bus_edges(30);
    por_n = 1'b0; bus_edges(2);
    por_n = 1'b1; bus_edges(1);
    rd_chk(4, 0, "R10 por ctrl");
    rd_chk(5, 0, "R10 por width");

    summary();
  end
endmodule